// File: doc/BRIEF.md
# Mailbox Receive Queue with Software-Visible Pointers

This block is the receive side of an inter-core mailbox. Remote senders, merged ahead of this block into a single push port, deliver messages of 64 data bits plus a channel number. Each message goes into a circular queue. Software looks at the oldest entry through three read-only registers: channel number, lower data word and upper data word. It then writes a pop command to retire that entry.

The block never reports a fill level. Instead, a status register shows the raw 8-bit write and read positions and a full flag. Software works out the level itself. Equal positions mean the queue is empty, or holds the whole depth when the full flag is set. Otherwise the level is write minus read, with the depth added when the read position has wrapped past the write position. A separate register reports the depth minus one.

Every accepted message sets a sticky pending flag. That flag drives an interrupt line unless a mask bit blocks it. Writing zero to a clear register empties the queue at once.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After synchronous reset, the status register (offset 0x14) reads 0, the irq pin and the irq status register (0x18) read 0, the mask register (0x1C) reads 0x1F, and the depth register (0x24) reads DEPTH-1.
- R2: Accepted messages leave in arrival order. The oldest entry's channel number reads at 0x00, data bits 31:0 at 0x04 and data bits 63:32 at 0x08.
- R3: The status register holds the write position in bits 23:16, the read position in bits 31:24 and the full flag in bit 2, with all other bits zero. Each position advances by one per accepted push or pop and wraps from DEPTH-1 to 0. The full flag is only ever set while the two positions are equal.
- R4: After DEPTH accepted pushes with no pop, the full flag is set. A push while full is discarded, so both positions, the full flag and the head entry stay unchanged.
- R5: A write to 0x0C with bit 0 set retires the head entry. Such a write while the queue is empty has no effect.
- R6: A push and a pop in the same cycle both take effect when the queue is neither empty nor full. When the queue is full, only the pop takes effect.
- R7: Each accepted push sets a pending flag, which reads as bit 0 of 0x18. Writing 1 to bit 0 of 0x18 clears the flag. The irq pin equals the pending flag while mask bit 0 is 0, and stays low while mask bit 0 is 1.
- R8: The mask register stores the five least significant bits written to it and reads them back.
- R9: Writing the value 0 to 0x10 empties the queue and clears both positions, the full flag and the pending flag. Writing a nonzero value there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Incoming message present this cycle |
| push_data | input | 64 | Incoming message payload |
| push_chan | input | CHAN_W | Incoming message channel number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Not-empty interrupt, active high |

## Verification
The assertions check four things on every cycle: both positions stay inside the depth, a full queue keeps both positions and its full flag when a push arrives alone, a pop write to an empty queue leaves the read position alone, and the clear write always returns the positions to zero. They also check that the mask forces the irq pin low and that a status clear with no push drops the pin. Some behaviour only the bench scenarios can show. These are the order and content of messages across a wrap, the push-and-pop cycle in a full queue, the nonzero clear write that must do nothing, and the register field layout that software uses to compute the fill level.

// File: rtl/mbrx_pkg.sv
// Package for the mailbox receive queue.
// Holds the register byte offsets and the status field positions. Software
// decodes these positions, so they are fixed.
package mbrx_pkg;
    localparam logic [7:0] OFS_CHAN  = 8'h00;
    localparam logic [7:0] OFS_LO    = 8'h04;
    localparam logic [7:0] OFS_HI    = 8'h08;
    localparam logic [7:0] OFS_POP   = 8'h0C;
    localparam logic [7:0] OFS_CLR   = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_ISTAT = 8'h18;
    localparam logic [7:0] OFS_IMASK = 8'h1C;
    localparam logic [7:0] OFS_DEPTH = 8'h24;

    localparam int MASK_W       = 5;
    localparam int STAT_FULL    = 2;
    localparam int STAT_WR_LSB  = 16;
    localparam int STAT_RD_LSB  = 24;
endpackage

// File: rtl/mbrx_ptrs.sv
// Write and read positions plus the full flag of the circular queue.
// Assumes DEPTH is 2..256. Any depth works because wrap compares against
// DEPTH-1 rather than relying on a power of two. A clear request beats
// both push and pop. A push counts only if the queue is not full before
// the cycle, so a pop in the same cycle cannot make room for it.
module mbrx_ptrs #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             clr_req,
    output logic             push_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic             empty;
    logic             pop_ok;
    logic [PTR_W-1:0] wr_nxt;
    logic [PTR_W-1:0] rd_nxt;

    // Qualify requests and compute the wrapped next positions.
    always_comb begin
        empty   = (wr_ptr == rd_ptr) && !full;
        push_ok = push_req && !full && !clr_req;
        pop_ok  = pop_req && !empty && !clr_req;
        wr_nxt  = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        rd_nxt  = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Update the positions and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            full   <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            if (push_ok && !pop_ok && (wr_nxt == rd_ptr))
                full <= 1'b1;
            else if (pop_ok && !push_ok)
                full <= 1'b0;
        end
    end
endmodule

// File: rtl/mbrx_store.sv
// Entry storage. It writes one entry at the write position and reads the
// entry at the read position combinationally. The entries are not reset:
// their content means nothing until a push has written them.
module mbrx_store #(
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int DATA_W = 64,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CHAN_W-1:0] rd_chan
);
    localparam int ENT_W = DATA_W + CHAN_W;

    logic [ENT_W-1:0] mem [DEPTH];

    // Capture an accepted message.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= {wr_chan, wr_data};
    end

    // Present the head entry.
    always_comb begin
        {rd_chan, rd_data} = mem[rd_idx];
    end
endmodule

// File: rtl/mbrx_regs.sv
// Register decode, pending flag, mask and read mux.
// Assumes single-cycle writes on reg_we and combinational reads from
// reg_addr. Pop and clear are decoded here and acted on in mbrx_ptrs.
module mbrx_regs
    import mbrx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              push_ok,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic              full,
    input  logic [63:0]       head_data,
    input  logic [CHAN_W-1:0] head_chan,
    output logic              pop_req,
    output logic              clr_req,
    output logic              pending,
    output logic [MASK_W-1:0] imask,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic ack_req;

    // Decode the write-side commands.
    always_comb begin
        pop_req = reg_we && (reg_addr == OFS_POP)   && reg_wdata[0];
        clr_req = reg_we && (reg_addr == OFS_CLR)   && (reg_wdata == '0);
        ack_req = reg_we && (reg_addr == OFS_ISTAT) && reg_wdata[0];
    end

    // Sticky pending flag. Clear beats push, and push beats acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) pending <= 1'b0;
        else if (push_ok)      pending <= 1'b1;
        else if (ack_req)      pending <= 1'b0;
    end

    // Mask register; every source is masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            imask <= '1;
        else if (reg_we && (reg_addr == OFS_IMASK))
            imask <= reg_wdata[MASK_W-1:0];
    end

    // Interrupt line.
    always_comb irq = pending && !imask[0];

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CHAN:  reg_rdata = 32'(head_chan);
            OFS_LO:    reg_rdata = head_data[31:0];
            OFS_HI:    reg_rdata = head_data[63:32];
            OFS_STAT: begin
                reg_rdata[STAT_RD_LSB +: 8] = 8'(rd_ptr);
                reg_rdata[STAT_WR_LSB +: 8] = 8'(wr_ptr);
                reg_rdata[STAT_FULL]        = full;
            end
            OFS_ISTAT: reg_rdata[0] = pending;
            OFS_IMASK: reg_rdata[MASK_W-1:0] = imask;
            OFS_DEPTH: reg_rdata = 32'(DEPTH - 1);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_rx_fifo.sv
// Top of the mailbox receive queue. It joins the position logic, the entry
// storage and the register block. Senders must already be merged into the
// one push port. A push while full is dropped without any signal.
module mbox_rx_fifo
    import mbrx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [63:0]       push_data,
    input  logic [CHAN_W-1:0] push_chan,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              push_ok;
    logic              pop_req;
    logic              clr_req;
    logic              full;
    logic              pending;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [63:0]       head_data;
    logic [CHAN_W-1:0] head_chan;
    logic [MASK_W-1:0] imask;

    mbrx_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .clr_req  (clr_req),
        .push_ok  (push_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .full     (full)
    );

    mbrx_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DATA_W(64), .CHAN_W(CHAN_W)) u_store (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (wr_ptr),
        .wr_data (push_data),
        .wr_chan (push_chan),
        .rd_idx  (rd_ptr),
        .rd_data (head_data),
        .rd_chan (head_chan)
    );

    mbrx_regs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CHAN_W(CHAN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .push_ok   (push_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (full),
        .head_data (head_data),
        .head_chan (head_chan),
        .pop_req   (pop_req),
        .clr_req   (clr_req),
        .pending   (pending),
        .imask     (imask),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/mbox_rx_fifo_chk.sv
// Property checker for mbox_rx_fifo. It decodes register writes again from
// the ports and watches the internal positions, the full flag and the mask.
// A bind statement attaches it to the top module.
module mbox_rx_fifo_chk
    import mbrx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic              full,
    input logic [MASK_W-1:0] imask
);
    logic pop_wr;
    logic clr_wr;
    logic ack_wr;

    // Decode the host writes independently of the register block.
    always_comb begin
        pop_wr = reg_we && reg_addr == 8'h0C && reg_wdata[0];
        clr_wr = reg_we && reg_addr == 8'h10 && reg_wdata == 32'd0;
        ack_wr = reg_we && reg_addr == 8'h18 && reg_wdata[0];
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(wr_ptr) < DEPTH) && (int'(rd_ptr) < DEPTH));  // R3
    AST_FULL_PTRS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (wr_ptr == rd_ptr));  // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_valid && !pop_wr && !clr_wr) |=> ($stable(wr_ptr) && $stable(rd_ptr) && full));  // R4
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_ptr == rd_ptr) && !full && pop_wr && !push_valid) |=> $stable(rd_ptr));  // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        imask[0] |-> !irq);  // R7
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !push_valid) |=> !irq);  // R7
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (wr_ptr == '0 && rd_ptr == '0 && !full));  // R9
endmodule

bind mbox_rx_fifo mbox_rx_fifo_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .full       (full),
    .imask      (imask)
);

// File: tb/mbox_rx_fifo_tb.sv
// Testbench for mbox_rx_fifo. A table of messages is walked in one loop,
// then directed tests cover the corner cases. A queue model kept here from
// the requirements provides every expected value.
module mbox_rx_fifo_tb;
    localparam int D  = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [63:0]   push_data = '0;
    logic [CW-1:0] push_chan = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [66:0] mdl [D];
    int mwr = 0, mrd = 0, mcnt = 0;

    // Each entry is {channel, data}.
    localparam logic [66:0] VEC [6] = '{
        {3'd5, 64'h0123_4567_89AB_CDEF},
        {3'd0, 64'hFFFF_FFFF_0000_0000},
        {3'd7, 64'h0000_0000_FFFF_FFFF},
        {3'd2, 64'hA5A5_5A5A_C3C3_3C3C},
        {3'd1, 64'h0000_0000_0000_0001},
        {3'd6, 64'h8000_0000_0000_0000}
    };

    mbox_rx_fifo #(.DEPTH(D), .CHAN_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_chan(push_chan), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Model update for one push and/or pop in the same cycle (R4, R6).
    task automatic mdl_step(input bit p, input logic [66:0] e, input bit q);
        bit pok, qok;
        pok = p && (mcnt < D);
        qok = q && (mcnt > 0);
        if (pok) begin mdl[mwr] = e; mwr = (mwr + 1) % D; end
        if (qok) mrd = (mrd + 1) % D;
        mcnt = mcnt + (pok ? 1 : 0) - (qok ? 1 : 0);
    endtask

    task automatic cycle(input bit p, input logic [66:0] e, input bit q);
        @(negedge clk);
        push_valid = p; {push_chan, push_data} = e;
        reg_we = q; reg_addr = 8'h0C; reg_wdata = 32'd1;
        @(negedge clk);
        push_valid = 1'b0; reg_we = 1'b0;
        mdl_step(p, e, q);
    endtask

    task automatic chk_stat(input string req);
        logic [31:0] d, e;
        e = '0;
        e[31:24] = 8'(mrd);
        e[23:16] = 8'(mwr);
        e[2] = (mcnt == D);
        rd(8'h14, d);
        chk(req, d, e);
    endtask

    task automatic chk_head(input string req);
        logic [31:0] d;
        rd(8'h00, d); chk(req, d, 32'(mdl[mrd][66:64]));
        rd(8'h04, d); chk(req, d, mdl[mrd][31:0]);
        rd(8'h08, d); chk(req, d, mdl[mrd][63:32]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk_stat("R1");
        rd(8'h18, d); chk("R1", d, 32'd0);
        rd(8'h1C, d); chk("R1", d, 32'h1F);
        rd(8'h24, d); chk("R1", d, 32'(D - 1));
        chk("R1", 32'(irq), 32'd0);

        // R3: push the table, checking the positions after each push
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, VEC[i], 1'b0);
            chk_stat("R3");
        end

        // R7: pending is set, but the line stays low while masked
        chk("R7", 32'(irq), 32'd0);
        rd(8'h18, d); chk("R7", d, 32'd1);
        wr(8'h1C, 32'h1E);
        chk("R7", 32'(irq), 32'd1);
        rd(8'h1C, d); chk("R8", d, 32'h1E);

        // R2/R5: drain in order
        for (int i = 0; i < 6; i++) begin
            chk_head("R2");
            cycle(1'b0, '0, 1'b1);
            chk_stat("R5");
        end

        // R7: acknowledge
        wr(8'h18, 32'd1);
        chk("R7", 32'(irq), 32'd0);

        // R5: pop while empty is ignored
        cycle(1'b0, '0, 1'b1);
        chk_stat("R5");

        // R4: fill across the wrap, then overflow
        for (int i = 0; i < D; i++)
            cycle(1'b1, {3'(i), 32'(i * 32'h1111), ~32'(i)}, 1'b0);
        chk_stat("R4");
        cycle(1'b1, {3'd7, 64'hEEEE_EEEE_EEEE_EEEE}, 1'b0);
        chk_stat("R4");
        chk_head("R4");

        // R6: push and pop while full, so only the pop takes effect
        cycle(1'b1, {3'd4, 64'hDEAD_BEEF_DEAD_BEEF}, 1'b1);
        chk_stat("R6");

        // R3: drain to one entry across the wrap
        while (mcnt > 1) begin
            chk_head("R3");
            cycle(1'b0, '0, 1'b1);
        end
        chk_stat("R3");

        // R6: push and pop with one entry
        cycle(1'b1, {3'd3, 64'h1357_9BDF_2468_ACE0}, 1'b1);
        chk_stat("R6");
        chk_head("R6");

        // R9: a nonzero clear write is ignored, and zero clears
        chk("R7", 32'(irq), 32'd1);
        wr(8'h10, 32'd5);
        chk_stat("R9");
        wr(8'h10, 32'd0);
        mwr = 0; mrd = 0; mcnt = 0;
        chk_stat("R9");
        chk("R9", 32'(irq), 32'd0);
        rd(8'h18, d); chk("R9", d, 32'd0);

        // R8: mask width
        wr(8'h1C, 32'h0A);
        rd(8'h1C, d); chk("R8", d, 32'h0A);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R8", d, 32'h1F);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule